// File: doc/BRIEF.md
# Bounded Triangle Wave Generator

This block drives the parallel code of a resistor-ladder digital-to-analog converter with a triangle wave. An up/down counter climbs from zero to a programmable peak and then walks back down. Each code stays on the output for a programmable number of enabled clock cycles, so the hold length sets the output frequency. The descent stops at 1, and the next period begins again at 0. One period is therefore exactly 2*peak steps long.

The peak input is one bit narrower than the sample, so the most significant output bit never switches. This keeps the ladder away from its large glitch at mid-scale, where every lower bit falls at the same moment the top bit rises. With the default 8-bit sample the peak tops out at 127, and the wave spans half of the ladder range.

The peak and hold inputs are captured only at reset and at the start of each period. A change made mid-period therefore never produces a broken ramp. The enable input freezes the whole generator in place. A one-cycle pulse marks each return to code 0.

Top module: `tri_wave_gen`

## Requirements
- R1: During and after synchronous reset, until the first enabled step, `sample_o` is 0, `falling_o` is 0 (rising) and `period_start_o` is 0. Reset captures the peak and hold inputs present at that time.
- R2: In the rising phase, `falling_o` is 0 and `sample_o` takes every code 0, 1, ..., P-1 in order, one per step, where P is the captured peak.
- R3: The step after code P-1 shows code P with `falling_o` = 1. Later steps show P-1, ..., down to 1, with `falling_o` = 1.
- R4: The step after code 1 in the falling phase shows code 0 with `falling_o` = 0. `period_start_o` is 1 for exactly the first clock cycle of that code 0. A period is 2*P steps.
- R5: Each code is held for D enabled clock cycles, where D is the captured hold value; a hold value of 0 is treated as 1.
- R6: A peak value of 0 is treated as 1. The sample never exceeds the captured peak. Bit DATA_W-1 of `sample_o` is always 0.
- R7: Changes on `peak_i` or `hold_i` have no effect until the next return to code 0. That return captures the input values present in its cycle.
- R8: While `en_i` is 0, `sample_o`, `falling_o` and the hold count stay unchanged. An edge with `en_i` = 0 does not count towards the hold length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Advance enable; low freezes the generator |
| peak_i | input | DATA_W-1 | Peak code (0 treated as 1) |
| hold_i | input | HOLD_W | Enabled cycles per code (0 treated as 1) |
| sample_o | output | DATA_W | Code to the resistor ladder |
| falling_o | output | 1 | 1 while the ramp is descending |
| period_start_o | output | 1 | One-cycle pulse on the first cycle of each new period |

## Verification
On every cycle, the assertions check these local rules:
- single-step increments while rising and single-step decrements while falling;
- the code never exceeds the captured peak;
- the hold count never reaches zero;
- the state freezes while the enable is low;
- the captured configuration does not move between period starts.

Only the bench's scenarios can show the whole-period properties. These are the exact 2*P step count, the D-cycle hold of each code, and the placement of the start pulse. They also cover how a zero peak or zero hold is treated, and when a mid-period change to the configuration first takes effect. The bench compares each cycle against a closed-form position-in-period formula. It does this over a sweep of peaks and holds, an irregular enable pattern, and a mid-period reconfiguration.

// File: rtl/tri_pkg.sv
package tri_pkg;
   typedef enum logic {
      DIR_UP   = 1'b0,
      DIR_DOWN = 1'b1
   } dir_e;
endpackage

// File: rtl/tri_cfg_latch.sv
module tri_cfg_latch #(
   parameter int PEAK_W = 7,
   parameter int HOLD_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              load_i,
   input  logic [PEAK_W-1:0] peak_i,
   input  logic [HOLD_W-1:0] hold_i,
   output logic [PEAK_W-1:0] peak_o,
   output logic [HOLD_W-1:0] hold_o,
   output logic [HOLD_W-1:0] reload_o
);
   logic [PEAK_W-1:0] peak_fl;
   logic [HOLD_W-1:0] hold_fl;
   logic [PEAK_W-1:0] peak_q;
   logic [HOLD_W-1:0] hold_q;

   // zero on either input is promoted to one
   assign peak_fl = (peak_i == '0) ? PEAK_W'(1) : peak_i;
   assign hold_fl = (hold_i == '0) ? HOLD_W'(1) : hold_i;

   always_ff @(posedge clk_i) begin
      if (load_i) begin
         peak_q <= peak_fl;
         hold_q <= hold_fl;
      end
   end

   // a period start reloads the timer with the freshly captured length
   assign reload_o = load_i ? hold_fl : hold_q;
   assign peak_o   = peak_q;
   assign hold_o   = hold_q;

   assert_cfg_stable_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      !load_i |=> ($stable(peak_q) && $stable(hold_q)));

   assert_peak_nonzero_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      peak_q != '0);
endmodule

// File: rtl/tri_hold_timer.sv
module tri_hold_timer #(
   parameter int HOLD_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              en_i,
   input  logic [HOLD_W-1:0] reload_i,
   output logic              tick_o
);
   logic [HOLD_W-1:0] cnt_q;

   assign tick_o = en_i && (cnt_q <= HOLD_W'(1));

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q <= reload_i;
      end else if (en_i) begin
         if (tick_o) cnt_q <= reload_i;
         else        cnt_q <= cnt_q - HOLD_W'(1);
      end
   end

   assert_hold_nonzero_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      cnt_q != '0);

   assert_timer_freeze_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      !en_i |=> $stable(cnt_q));
endmodule

// File: rtl/tri_ramp_core.sv
module tri_ramp_core
   import tri_pkg::*;
#(
   parameter int PEAK_W = 7
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              step_i,
   input  logic [PEAK_W-1:0] peak_i,
   output logic [PEAK_W-1:0] code_o,
   output dir_e              dir_o,
   output logic              wrap_o,
   output logic              start_o
);
   logic [PEAK_W-1:0] code_q;
   logic [PEAK_W-1:0] code_inc;
   dir_e              dir_q;
   logic              start_q;

   assign code_inc = code_q + PEAK_W'(1);
   assign wrap_o   = step_i && (dir_q == DIR_DOWN) && (code_q == PEAK_W'(1));

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         code_q  <= '0;
         dir_q   <= DIR_UP;
         start_q <= 1'b0;
      end else begin
         start_q <= wrap_o;
         if (step_i) begin
            if (dir_q == DIR_UP) begin
               code_q <= code_inc;
               if (code_inc == peak_i) dir_q <= DIR_DOWN;
            end else if (code_q == PEAK_W'(1)) begin
               code_q <= '0;
               dir_q  <= DIR_UP;
            end else begin
               code_q <= code_q - PEAK_W'(1);
            end
         end
      end
   end

   assign code_o  = code_q;
   assign dir_o   = dir_q;
   assign start_o = start_q;

   assert_rise_inc_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      (step_i && dir_q == DIR_UP) |=> (code_q == $past(code_q) + PEAK_W'(1)));

   assert_fall_dec_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      (step_i && dir_q == DIR_DOWN && code_q != PEAK_W'(1))
      |=> (code_q == $past(code_q) - PEAK_W'(1) && dir_q == DIR_DOWN));

   assert_start_at_zero_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      start_q |-> (code_q == '0 && dir_q == DIR_UP));

   assert_code_cap_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      code_q <= peak_i);

   assert_freeze_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      !step_i |=> ($stable(code_q) && $stable(dir_q)));
endmodule

// File: rtl/tri_wave_gen.sv
module tri_wave_gen
   import tri_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int HOLD_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              en_i,
   input  logic [DATA_W-2:0] peak_i,
   input  logic [HOLD_W-1:0] hold_i,
   output logic [DATA_W-1:0] sample_o,
   output logic              falling_o,
   output logic              period_start_o
);
   localparam int PEAK_W = DATA_W - 1;

   generate
      if (DATA_W < 2 || DATA_W > 16) begin : g_bad_data_w
         $error("tri_wave_gen: DATA_W must lie in 2..16");
      end
      if (HOLD_W < 1 || HOLD_W > 24) begin : g_bad_hold_w
         $error("tri_wave_gen: HOLD_W must lie in 1..24");
      end
   endgenerate

   logic [PEAK_W-1:0] peak_cur;
   logic [HOLD_W-1:0] hold_cur;
   logic [HOLD_W-1:0] hold_reload;
   logic [PEAK_W-1:0] code;
   dir_e              dir;
   logic              step;
   logic              wrap;
   logic              start;
   logic              load;

   assign load = rst_i || wrap;

   tri_cfg_latch #(.PEAK_W(PEAK_W), .HOLD_W(HOLD_W)) u_cfg (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .load_i   (load),
      .peak_i   (peak_i),
      .hold_i   (hold_i),
      .peak_o   (peak_cur),
      .hold_o   (hold_cur),
      .reload_o (hold_reload)
   );

   tri_hold_timer #(.HOLD_W(HOLD_W)) u_timer (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .en_i     (en_i),
      .reload_i (hold_reload),
      .tick_o   (step)
   );

   tri_ramp_core #(.PEAK_W(PEAK_W)) u_core (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .step_i  (step),
      .peak_i  (peak_cur),
      .code_o  (code),
      .dir_o   (dir),
      .wrap_o  (wrap),
      .start_o (start)
   );

   // the top ladder bit is tied low: the peak cannot reach it
   assign sample_o       = {1'b0, code};
   assign falling_o      = (dir == DIR_DOWN);
   assign period_start_o = start;

   assert_start_one_cycle_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      period_start_o |=> !period_start_o);

   assert_hold_cap_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      hold_cur != '0);
endmodule

// File: tb/tb_tri_wave_gen.sv
`timescale 1ns/1ps
module tb_tri_wave_gen;
   localparam int DATA_W = 8;
   localparam int HOLD_W = 8;

   logic              clk_i = 1'b0;
   logic              rst_i = 1'b1;
   logic              en_i  = 1'b0;
   logic [DATA_W-2:0] peak_i = '0;
   logic [HOLD_W-1:0] hold_i = '0;
   logic [DATA_W-1:0] sample_o;
   logic              falling_o;
   logic              period_start_o;

   tri_wave_gen #(.DATA_W(DATA_W), .HOLD_W(HOLD_W)) dut (
      .clk_i          (clk_i),
      .rst_i          (rst_i),
      .en_i           (en_i),
      .peak_i         (peak_i),
      .hold_i         (hold_i),
      .sample_o       (sample_o),
      .falling_o      (falling_o),
      .period_start_o (period_start_o)
   );

   always #4 clk_i = ~clk_i;

   int n_checks = 0;
   int n_err    = 0;
   bit done     = 1'b0;

   // closed-form model: position t (enabled edges) inside the current period
   int m_p, m_d, m_t;
   bit m_start;

   function automatic int fl(int v);
      return (v == 0) ? 1 : v;
   endfunction

   task automatic chk(bit ok, string tag, string what, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic check_outputs(string ctx);
      int s, e_code;
      bit e_fall;
      s      = m_t / m_d;
      e_fall = (s >= m_p);
      e_code = e_fall ? (2 * m_p - s) : s;
      chk(sample_o == DATA_W'(e_code), e_fall ? "R3" : "R2",
          {ctx, " sample"}, int'(sample_o), e_code);
      chk(falling_o == e_fall, e_fall ? "R3" : "R2",
          {ctx, " direction"}, int'(falling_o), int'(e_fall));
      chk(period_start_o == m_start, "R4", {ctx, " start pulse"},
          int'(period_start_o), int'(m_start));
      chk(sample_o[DATA_W-1] == 1'b0, "R6", {ctx, " top bit"},
          int'(sample_o[DATA_W-1]), 0);
   endtask

   task automatic do_reset(int pk, int hd);
      @(negedge clk_i);
      rst_i  = 1'b1;
      en_i   = 1'b1;
      peak_i = (DATA_W-1)'(pk);
      hold_i = HOLD_W'(hd);
      repeat (3) @(negedge clk_i);
      chk(sample_o == '0 && falling_o == 1'b0 && period_start_o == 1'b0,
          "R1", "outputs in reset", int'(sample_o), 0);
      rst_i   = 1'b0;
      m_p     = fl(pk);
      m_d     = fl(hd);
      m_t     = 0;
      m_start = 1'b0;
   endtask

   task automatic run_cycle(bit en_val, string ctx);
      en_i = en_val;
      @(posedge clk_i);
      @(negedge clk_i);
      if (en_val) begin
         m_t++;
         m_start = 1'b0;
         if (m_t == 2 * m_p * m_d) begin
            m_t     = 0;
            m_p     = fl(int'(peak_i));
            m_d     = fl(int'(hold_i));
            m_start = 1'b1;
         end
      end else begin
         m_start = 1'b0;
      end
      check_outputs(ctx);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk_i);
      n_err++;
      $display("FAIL watchdog: all requirements: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int peaks[6] = '{0, 1, 2, 3, 5, 127};
      int holds[4] = '{0, 1, 2, 3};

      // R1: reset state, and first cycle after release with enable low
      do_reset(5, 3);
      run_cycle(1'b0, "R1 post-reset");

      // R2 R3 R4 R5 R6: sweep peak and hold, two full periods each
      foreach (peaks[i]) begin
         foreach (holds[j]) begin
            do_reset(peaks[i], holds[j]);
            for (int c = 0; c < 2 * 2 * fl(peaks[i]) * fl(holds[j]) + 3; c++)
               run_cycle(1'b1, $sformatf("R5 sweep p=%0d d=%0d", peaks[i], holds[j]));
         end
      end

      // R8: irregular enable pattern freezes sample, direction and hold count
      do_reset(6, 3);
      for (int c = 0; c < 300; c++)
         run_cycle((c % 5 != 2) && (c % 13 != 0), "R8 gated");
      for (int c = 0; c < 12; c++)
         run_cycle(1'b0, "R8 long pause");
      for (int c = 0; c < 40; c++)
         run_cycle(1'b1, "R8 resume");

      // R7: mid-period change waits for the next return to zero
      do_reset(4, 2);
      for (int c = 0; c < 5; c++)
         run_cycle(1'b1, "R7 before change");
      peak_i = 7'd9;
      hold_i = 8'd1;
      for (int c = 0; c < 16 - 5 + 2 * 18 + 2; c++)
         run_cycle(1'b1, "R7 after change");
      peak_i = 7'd0;
      hold_i = 8'd0;
      for (int c = 0; c < 22; c++)
         run_cycle(1'b1, "R7 zero config");

      finish_run();
   end
endmodule